// File: doc/BRIEF.md
# Alternate Bus Master Request Controller

This block lets a device that is not the default bus owner take the shared bus, run a known number of transfers, and give the bus back. The device starts a job with a one-clock `start_i` pulse and a transfer count. The controller raises the bus request and waits for the grant. It then waits until the previous master has stopped driving the bus, the previous slave has finished its termination, and no other device holds the acknowledge line. Only then does it assert its own acknowledge.

Once it holds the bus, the controller drops the request and counts one transfer for each `cyc_done_i` pulse. After the last transfer it releases the acknowledge line. All signals are shown as active high. The bus-side inputs are asynchronous and pass through two-flop synchronizers, so every timing rule is expressed in clocks.

A static mode input can drop the slave-termination term from the release test. In that mode only the address strobe and the external acknowledge are checked.

Top module: `bus_claim_ctrl`

## Requirements
- R1: After reset, req_o, ack_o, drive_en_o and done_o are all low.
- R2: While idle, a start_i pulse with a nonzero len_i raises req_o in the following cycle. A start_i pulse with len_i equal to zero is ignored, and req_o stays low.
- R3: After the grant, ack_o stays low while strobe_i, any bit of term_i, or ack_ext_i is high. It rises once all of them have been low through the synchronizers.
- R4: req_o is still high in the first cycle in which ack_o is high, and it is low from the next cycle on.
- R5: When as_only_i is high, term_i has no effect on when ack_o rises. strobe_i and ack_ext_i still block it.
- R6: ack_o stays high until len_i pulses of cyc_done_i have been seen while ack_o is high. Pulses that arrive while ack_o is low are not counted.
- R7: drive_en_o equals ack_o in every cycle.
- R8: done_o is high for exactly one cycle: the first cycle in which ack_o is low after a job.
- R9: If the grant is withdrawn before ack_o rises, req_o stays high and ack_o stays low until the grant returns.
- R10: A start_i pulse while a job is in progress is ignored. Its length is not loaded, and no new request follows the current job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock job start from the device |
| len_i | input | CNT_W | Number of bus transfers in the job |
| cyc_done_i | input | 1 | One-clock pulse per completed transfer |
| as_only_i | input | 1 | Release test uses strobe and external acknowledge only |
| grant_i | input | 1 | Bus grant from the arbiter (asynchronous) |
| strobe_i | input | 1 | Address strobe of the current master (asynchronous) |
| term_i | input | N_TERM | Slave termination lines (asynchronous) |
| ack_ext_i | input | 1 | Acknowledge level driven by other masters (asynchronous) |
| req_o | output | 1 | Bus request |
| ack_o | output | 1 | Own bus-grant acknowledge |
| drive_en_o | output | 1 | Enable for the device's bus drivers |
| done_o | output | 1 | One-clock pulse when mastership ends |

## Verification
Two events can fall in the same cycle: the claim, where acknowledge rises while the request is still held, and the completion of the last transfer. The bench provokes this with a one-transfer job. It raises cyc_done_i in the very first cycle in which ack_o is seen high. It then checks that acknowledge lasts exactly one cycle, that done_o fires in the next cycle, and that the request is low by then. A second case withdraws the grant in the middle of the release wait and checks that the claim waits for the grant to come back.

// File: rtl/bus_claim_pkg.sv
package bus_claim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // no job
    ST_REQ,   // request raised, waiting for grant
    ST_GNT,   // granted, waiting for bus release
    ST_HOLD,  // first acknowledge cycle, request still high
    ST_RUN    // acknowledge high, request low
  } claim_state_e;
endpackage

// File: rtl/bus_claim_sync.sv
module bus_claim_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bus_claim_cnt.sv
module bus_claim_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= len_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/bus_claim_fsm.sv
module bus_claim_fsm
  import bus_claim_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic len_nz_i,
  input  logic grant_i,
  input  logic released_i,
  input  logic cyc_done_i,
  input  logic last_i,
  output logic load_o,
  output logic dec_o,
  output logic req_o,
  output logic ack_o,
  output logic done_o
);
  claim_state_e st_q, st_d;
  logic done_q;
  logic own;
  logic finish;

  assign own    = (st_q == ST_HOLD) || (st_q == ST_RUN);
  assign finish = own && cyc_done_i && last_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i && len_nz_i) st_d = ST_REQ;
      ST_REQ:  if (grant_i) st_d = ST_GNT;
      ST_GNT: begin
        if (!grant_i)        st_d = ST_REQ;  // grant lost: keep requesting
        else if (released_i) st_d = ST_HOLD;
      end
      ST_HOLD: st_d = finish ? ST_IDLE : ST_RUN;
      ST_RUN:  if (finish) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  assign load_o = (st_q == ST_IDLE) && start_i && len_nz_i;
  assign dec_o  = own && cyc_done_i;
  assign req_o  = (st_q == ST_REQ) || (st_q == ST_GNT) || (st_q == ST_HOLD);
  assign ack_o  = own;
  assign done_o = done_q;
endmodule

// File: rtl/bus_claim_ctrl.sv
module bus_claim_ctrl #(
  parameter int CNT_W   = 8,
  parameter int N_TERM  = 3,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              cyc_done_i,
  input  logic              as_only_i,
  input  logic              grant_i,
  input  logic              strobe_i,
  input  logic [N_TERM-1:0] term_i,
  input  logic              ack_ext_i,
  output logic              req_o,
  output logic              ack_o,
  output logic              drive_en_o,
  output logic              done_o
);
  localparam int SW = N_TERM + 3;

  logic [SW-1:0]     raw, syn;
  logic              grant_s, strobe_s, ack_ext_s;
  logic [N_TERM-1:0] term_s;
  logic              released;
  logic              load, dec, last;

  assign raw = {grant_i, strobe_i, ack_ext_i, term_i};

  bus_claim_sync #(.W(SW), .STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {grant_s, strobe_s, ack_ext_s, term_s} = syn;

  // Previous master, previous slave and any other holder must all be off the bus.
  assign released = !strobe_s && !ack_ext_s && (as_only_i || (term_s == '0));

  bus_claim_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len_i),
    .dec_i (dec),
    .last_o(last)
  );

  bus_claim_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_nz_i  (len_i != '0),
    .grant_i   (grant_s),
    .released_i(released),
    .cyc_done_i(cyc_done_i),
    .last_i    (last),
    .load_o    (load),
    .dec_o     (dec),
    .req_o     (req_o),
    .ack_o     (ack_o),
    .done_o    (done_o)
  );

  assign drive_en_o = ack_o;
endmodule

// File: rtl/bus_claim_ctrl_chk.sv
module bus_claim_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_done_i,
  input logic req_o,
  input logic ack_o,
  input logic drive_en_o,
  input logic done_o
);
  p_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o == ack_o);

  p_req_at_claim_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> req_o && $past(req_o));

  p_req_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> ack_o || done_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !cyc_done_i |=> ack_o);

  p_done_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ack_o && $past(ack_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind bus_claim_ctrl bus_claim_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cyc_done_i(cyc_done_i),
  .req_o     (req_o),
  .ack_o     (ack_o),
  .drive_en_o(drive_en_o),
  .done_o    (done_o)
);

// File: tb/bus_claim_ctrl_test.sv
module bus_claim_ctrl_test;
  localparam int CNT_W = 8;
  localparam int N_TERM = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, cyc_done_i = 0, as_only_i = 0;
  logic grant_i = 0, strobe_i = 0, ack_ext_i = 0;
  logic [CNT_W-1:0] len_i = '0;
  logic [N_TERM-1:0] term_i = '0;
  logic req_o, ack_o, drive_en_o, done_o;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_claim_ctrl #(.CNT_W(CNT_W), .N_TERM(N_TERM)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .cyc_done_i(cyc_done_i), .as_only_i(as_only_i), .grant_i(grant_i),
    .strobe_i(strobe_i), .term_i(term_i), .ack_ext_i(ack_ext_i),
    .req_o(req_o), .ack_o(ack_o), .drive_en_o(drive_en_o), .done_o(done_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick(input int len);
    @(negedge clk); start_i = 1; len_i = CNT_W'(len);
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_ack(output bit got);
    got = 0;
    for (int i = 0; i < 30 && !got; i++) begin
      @(negedge clk);
      got = ack_o;
    end
  endtask

  // one cyc_done pulse; returns state at the negedge after it was sampled
  task automatic pulse();
    cyc_done_i = 1;
    @(negedge clk); cyc_done_i = 0;
  endtask

  // {as_only, strobe, term, ext, ack expected while blockers held}
  localparam logic [4:0] VEC [8] = '{
    5'b0_1_0_0_0, 5'b0_0_1_0_0, 5'b0_0_0_1_0, 5'b0_0_0_0_1,
    5'b1_0_1_0_1, 5'b1_1_0_0_0, 5'b1_0_0_1_0, 5'b0_1_1_0_0};

  initial begin
    bit got;
    idle(2);
    chk(!req_o && !ack_o && !drive_en_o && !done_o, "R1 reset outputs", {req_o, ack_o, done_o}, 0);
    rst_ni = 1;
    idle(2);
    chk(!req_o && !ack_o && !drive_en_o && !done_o, "R1 after reset", {req_o, ack_o, done_o}, 0);

    for (int v = 0; v < 8; v++) begin
      as_only_i = VEC[v][4];
      strobe_i  = VEC[v][3];
      term_i    = VEC[v][2] ? 3'b010 : 3'b000;
      ack_ext_i = VEC[v][1];
      kick(2);
      chk(req_o == 1, "R2 request raised", req_o, 1);
      grant_i = 1;
      idle(8);
      chk(ack_o == VEC[v][0], VEC[v][4] ? "R5 as_only release" : "R3 release gate", ack_o, VEC[v][0]);
      strobe_i = 0; term_i = '0; ack_ext_i = 0;
      if (!VEC[v][0]) begin
        wait_ack(got);
        chk(got, "R3 claim after release", got, 1);
        chk(req_o == 1, "R4 req high on claim", req_o, 1);
        @(negedge clk);
        chk(req_o == 0, "R4 req dropped", req_o, 0);
      end
      chk(drive_en_o == ack_o, "R7 drive follows ack", drive_en_o, ack_o);
      pulse();
      chk(ack_o == 1, "R6 ack held mid job", ack_o, 1);
      pulse();
      chk(ack_o == 0 && done_o == 1, "R8 done on release", {ack_o, done_o}, 1);
      @(negedge clk);
      chk(done_o == 0 && drive_en_o == 0, "R8 done single", {done_o, drive_en_o}, 0);
      grant_i = 0;
      idle(4);
    end
    as_only_i = 0;

    // R2: zero length ignored
    kick(0);
    idle(4);
    chk(req_o == 0, "R2 zero length ignored", req_o, 0);

    // R9: grant withdrawn before claim
    strobe_i = 1;
    kick(1);
    grant_i = 1;
    idle(6);
    grant_i = 0;
    idle(4);
    strobe_i = 0;
    idle(8);
    chk(req_o == 1 && ack_o == 0, "R9 waiting after grant loss", {req_o, ack_o}, 2);
    // R6: pulses without ownership not counted
    pulse(); pulse(); pulse();
    grant_i = 1;
    wait_ack(got);
    chk(got, "R9 claim after regrant", got, 1);
    // concurrent: last transfer done in the first acknowledge cycle
    pulse();
    chk(ack_o == 0 && done_o == 1 && req_o == 0, "R6 single cycle job", {req_o, ack_o, done_o}, 1);
    grant_i = 0;
    idle(4);

    // R10: start during job ignored
    kick(1);
    grant_i = 1;
    wait_ack(got);
    start_i = 1; len_i = 8'd5;
    @(negedge clk); start_i = 0;
    chk(ack_o == 1, "R10 job continues", ack_o, 1);
    pulse();
    chk(ack_o == 0, "R10 old length kept", ack_o, 0);
    grant_i = 0;
    idle(6);
    chk(req_o == 0, "R10 no new request", req_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule